// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block sits next to a byte-wide serial shifter and lets software place start, repeated-start and stop conditions on a two-wire bus. An 8-bit control register, written in one cycle, carries three request bits and five mode bits. An owner bit decides who drives the open-drain clock and data lines. When it is 0, the shifter drives both lines, with an optional override that forces a chosen acknowledge level onto data. When it is 1, a small tick-paced sequencer drives them.

The same owner bit also decides what the single interrupt pulse means. With the shifter in charge, it flags start and stop conditions seen on the bus. With the sequencer in charge, it flags each finished generated condition. Two further mode bits manage the clock line. One lets go of clock once a stop is seen. The other holds clock low after the tenth falling clock edge of a transfer, counted from the start. Both drivers are modelled as pull-low enables, so 1 means the line is pulled low. The line inputs pass through a two-flop synchroniser.

The block moves no data stream, so it has no valid/ready interface. The register is written with a plain one-cycle write strobe, and every other pin is a level or a one-cycle pulse.

Top module: `i2c_cond_gen`

## Requirements
- R1: After an active-low asynchronous reset, the control readback is 0x00, both pull-low enables are 0 and irq is 0. A write strobe loads all 8 bits, and the value reads back on `ctrl_q` on the next cycle. Bit map: 0 start request, 1 restart request, 2 stop request, 3 owner select, 4 ack level, 5 ack override enable, 6 clock release on stop, 7 clock wait.
- R2: While bit 3 is 0, request bits stay set and are not served. `scl_oe` equals `sh_scl_oe`. `sda_oe` equals `sh_sda_oe`, except when bit 5 is 1: then `sda_oe` is the inverse of bit 4, so an ack level of 0 pulls data low.
- R3: While bit 3 is 1, the sequencer produces each condition as follows:
  - start: pull data low, then pull clock low one tick later.
  - stop: pull data low, release clock, then release data, one tick apart.
  - restart: release data, release clock, then run the start steps.
  - After a start or a restart both lines are pulled low. After a stop both lines are released.
- R4: When several request bits are set, they are served in the order stop, restart, start. Each bit clears itself on the cycle its sequence ends.
- R5: While bit 3 is 1, irq pulses exactly once for each finished condition, and never for a condition detected on the bus.
- R6: While bit 3 is 0, irq pulses once when data falls while clock is high (start) and once when data rises while clock is high (stop). A data change while clock is low gives no pulse.
- R7: With bit 6 set and bit 3 at 0, a detected stop releases the clock driver even if the shifter pulls clock low. Clearing bit 6, or a later start, restores shifter control.
- R8: With bit 7 set and `ext_clk` at 0, clock is pulled low from the 10th falling clock edge after a detected start. Clearing bit 7 releases it. With `ext_clk` at 1 there is no hold.
- R9: The sequencer changes its line drive only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled step strobe for the sequencer |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_q | output | 8 | Control register readback |
| sh_scl_oe | input | 1 | Shifter clock pull-low request |
| sh_sda_oe | input | 1 | Shifter data pull-low request |
| ext_clk | input | 1 | Clock is supplied externally; disables the wait hold |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| scl_oe | output | 1 | Clock pull-low enable |
| sda_oe | output | 1 | Data pull-low enable |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume `tick` is a single-cycle strobe and that the line inputs change slowly compared with the clock. A fresh start is assumed not to be detected in the very next cycle after another one. The bench spaces its ticks four cycles apart and keeps each line level for several cycles. It writes the register only while the sequencer is idle, so a software write never races a self-clear.

// File: rtl/i2c_cg_pkg.sv
package i2c_cg_pkg;
  localparam int CB_START   = 0;
  localparam int CB_RESTART = 1;
  localparam int CB_STOP    = 2;
  localparam int CB_OWNER   = 3;
  localparam int CB_ACKVAL  = 4;
  localparam int CB_ACKEN   = 5;
  localparam int CB_RELSTOP = 6;
  localparam int CB_WAIT    = 7;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_STOP    = 2'd1,
    OP_RESTART = 2'd2,
    OP_START   = 2'd3
  } cg_op_e;
endpackage

// File: rtl/cg_line_detect.sv
module cg_line_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic start_det_o,
  output logic stop_det_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr   <= '1;
      sda_sr   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sr   <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr   <= {sda_sr[STAGES-2:0], sda_i};
      scl_prev <= scl_sr[STAGES-1];
      sda_prev <= sda_sr[STAGES-1];
    end
  end

  assign scl_s_o     = scl_sr[STAGES-1];
  assign start_det_o = scl_sr[STAGES-1] & scl_prev & sda_prev & ~sda_sr[STAGES-1];
  assign stop_det_o  = scl_sr[STAGES-1] & scl_prev & ~sda_prev & sda_sr[STAGES-1];
  assign scl_fall_o  = scl_prev & ~scl_sr[STAGES-1];

  // R6
  det_start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det_o |=> !start_det_o);
endmodule

// File: rtl/cg_sequencer.sv
module cg_sequencer
  import i2c_cg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       owner_i,
  input  logic [2:0] req_i,
  output logic       scl_lo_o,
  output logic       sda_lo_o,
  output logic [2:0] clr_o,
  output logic       done_o
);
  cg_op_e     op_q, cur_op, pick;
  logic [1:0] step_q;
  logic       scl_lo_q, sda_lo_q, nx_scl, nx_sda, last;
  logic [2:0] mask;

  always_comb begin
    if (req_i[CB_STOP])         pick = OP_STOP;
    else if (req_i[CB_RESTART]) pick = OP_RESTART;
    else if (req_i[CB_START])   pick = OP_START;
    else                        pick = OP_NONE;
    cur_op = (op_q == OP_NONE) ? pick : op_q;
    nx_sda = sda_lo_q;
    nx_scl = scl_lo_q;
    last   = 1'b0;
    mask   = 3'b000;
    case (cur_op)
      OP_START: begin
        mask = 3'b001;
        if (step_q == 2'd0) nx_sda = 1'b1;
        else begin nx_scl = 1'b1; last = 1'b1; end
      end
      OP_STOP: begin
        mask = 3'b100;
        case (step_q)
          2'd0:    nx_sda = 1'b1;
          2'd1:    nx_scl = 1'b0;
          default: begin nx_sda = 1'b0; last = 1'b1; end
        endcase
      end
      OP_RESTART: begin
        mask = 3'b010;
        case (step_q)
          2'd0: nx_sda = 1'b0;
          2'd1: nx_scl = 1'b0;
          2'd2: nx_sda = 1'b1;
          default: begin nx_scl = 1'b1; last = 1'b1; end
        endcase
      end
      default: ;
    endcase
  end

  assign clr_o = (owner_i && tick_i && last) ? mask : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      step_q   <= 2'd0;
      scl_lo_q <= 1'b0;
      sda_lo_q <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!owner_i) begin
        op_q   <= OP_NONE;
        step_q <= 2'd0;
      end else if (tick_i && cur_op != OP_NONE) begin
        sda_lo_q <= nx_sda;
        scl_lo_q <= nx_scl;
        if (last) begin
          op_q   <= OP_NONE;
          step_q <= 2'd0;
          done_o <= 1'b1;
        end else begin
          op_q   <= cur_op;
          step_q <= step_q + 2'd1;
        end
      end
    end
  end

  assign scl_lo_o = scl_lo_q;
  assign sda_lo_o = sda_lo_q;

  // R9
  seq_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> ($stable(sda_lo_q) && $stable(scl_lo_q)));
endmodule

// File: rtl/cg_scl_wait.sv
module cg_scl_wait #(
  parameter int EDGE_CNT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_en_i,
  input  logic ext_clk_i,
  input  logic start_det_i,
  input  logic scl_fall_i,
  output logic hold_o
);
  localparam int CW = $clog2(EDGE_CNT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(EDGE_CNT);
  logic [CW-1:0] cnt_q;
  logic          armed;

  assign armed  = wait_en_i & ~ext_clk_i;
  assign hold_o = armed & (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (start_det_i)              cnt_q <= '0;
    else if (cnt_q == LIMIT && !armed) cnt_q <= '0;
    else if (scl_fall_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !start_det_i) |=> (hold_o || !wait_en_i || ext_clk_i));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_EDGE   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  input  logic       sh_scl_oe,
  input  logic       sh_sda_oe,
  input  logic       ext_clk,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  logic [7:0] ctrl_r;
  logic       scl_s, start_det, stop_det, scl_fall;
  logic       gen_scl, gen_sda, done, hold, rel_q;
  logic [2:0] clr;

  cg_line_detect #(.STAGES(SYNC_STAGES)) det_u (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .scl_s_o(scl_s), .start_det_o(start_det), .stop_det_o(stop_det),
    .scl_fall_o(scl_fall));

  cg_sequencer seq_u (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .owner_i(ctrl_r[CB_OWNER]),
    .req_i(ctrl_r[2:0]), .scl_lo_o(gen_scl), .sda_lo_o(gen_sda),
    .clr_o(clr), .done_o(done));

  cg_scl_wait #(.EDGE_CNT(WAIT_EDGE)) wait_u (
    .clk(clk), .rst_n(rst_n), .wait_en_i(ctrl_r[CB_WAIT]), .ext_clk_i(ext_clk),
    .start_det_i(start_det), .scl_fall_i(scl_fall), .hold_o(hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= 8'h00;
      rel_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_en) ctrl_r <= wr_data;
      else       ctrl_r[2:0] <= ctrl_r[2:0] & ~clr;
      if (!ctrl_r[CB_RELSTOP] || start_det) rel_q <= 1'b0;
      else if (stop_det)                    rel_q <= 1'b1;
      irq <= ctrl_r[CB_OWNER] ? done : (start_det | stop_det);
    end
  end

  always_comb begin
    if (ctrl_r[CB_OWNER]) begin
      scl_oe = gen_scl | hold;
      sda_oe = gen_sda;
    end else begin
      scl_oe = (sh_scl_oe & ~rel_q) | hold;
      sda_oe = ctrl_r[CB_ACKEN] ? ~ctrl_r[CB_ACKVAL] : sh_sda_oe;
    end
  end

  assign ctrl_q = ctrl_r;

  // R4
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ((($past(ctrl_r[2:0]) & ~ctrl_r[2:0]) & ~$past(clr)) == 3'b000));

  // R5
  owner_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(ctrl_r[CB_OWNER])) |-> $past(done));
endmodule

// File: tb/i2c_cond_gen_tb_top.sv
module i2c_cond_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic sh_scl = 1'b0, sh_sda = 1'b0, ext_clk = 1'b0;
  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  logic [7:0] ctrl_q;
  logic scl_oe, sda_oe, irq;
  wire  scl_line = !(scl_oe || tb_scl_low);
  wire  sda_line = !(sda_oe || tb_sda_low);
  int   vecs = 0, errs = 0;

  always #4 clk = ~clk;

  i2c_cond_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .sh_scl_oe(sh_scl), .sh_sda_oe(sh_sda), .ext_clk(ext_clk),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .irq(irq));

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 4;
      tick = (c == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_irq(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin @(negedge clk); if (irq) cnt++; end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    int n;
    idle(3);
    // R1 reset state
    chk("R1 ctrl reset", ctrl_q, 0);
    chk("R1 scl reset", scl_oe, 0);
    chk("R1 sda reset", sda_oe, 0);
    chk("R1 irq reset", irq, 0);
    rst_n = 1'b1;
    idle(3);
    wr(8'h30);
    chk("R1 readback", ctrl_q, 8'h30);

    // R2 exhaustive mux sweep with owner = 0
    for (int v = 0; v < 32; v++) begin
      wr({2'b00, v[3], v[2], 4'b0000});
      @(negedge clk); sh_scl = v[0]; sh_sda = v[1];
      idle(2);
      chk("R2 scl follow", scl_oe, v[0]);
      chk("R2 sda mux", sda_oe, v[3] ? !v[2] : v[1]);
    end
    sh_scl = 1'b0; sh_sda = 1'b0;
    wr(8'h00); idle(10);

    // R2 requests not served while owner = 0
    wr(8'h07); idle(40);
    chk("R2 req held", ctrl_q, 8'h07);
    chk("R2 sda untouched", sda_oe, 0);
    wr(8'h00); idle(10);

    // R3 R4 R5 sweep over every request combination
    for (int m = 1; m < 8; m++) begin
      logic [2:0] rem, hit;
      int to;
      rem = 3'(m);
      wr(8'h08 | 8'(m));
      to = 0;
      while (rem != 0 && to < 300) begin
        @(negedge clk); to++;
        if (irq) begin
          hit = rem[2] ? 3'b100 : (rem[1] ? 3'b010 : 3'b001);
          rem = rem & ~hit;
          chk("R4 order/self-clear", ctrl_q[2:0], rem);
        end
      end
      chk("R5 one irq per condition", rem, 0);
      count_irq(30, n);
      chk("R5 no extra irq", n, 0);
      chk("R3 final scl", scl_oe, (m[0] || m[1]) ? 1 : 0);
      chk("R3 final sda", sda_oe, (m[0] || m[1]) ? 1 : 0);
    end
    // leave lines released with owner still set, then hand back
    wr(8'h0C); idle(40);
    chk("R3 stop releases scl", scl_oe, 0);
    chk("R3 stop releases sda", sda_oe, 0);
    wr(8'h00); idle(10);

    // R6 detection with owner = 0
    @(negedge clk); tb_sda_low = 1'b1;
    count_irq(10, n); chk("R6 start detect", n, 1);
    @(negedge clk); tb_scl_low = 1'b1; idle(5);
    @(negedge clk); tb_sda_low = 1'b0;
    count_irq(10, n); chk("R6 sda rise scl low", n, 0);
    @(negedge clk); tb_sda_low = 1'b1;
    count_irq(10, n); chk("R6 sda fall scl low", n, 0);
    @(negedge clk); tb_scl_low = 1'b0;
    count_irq(10, n); chk("R6 scl rise", n, 0);
    @(negedge clk); tb_sda_low = 1'b0;
    count_irq(10, n); chk("R6 stop detect", n, 1);

    // R7 clock release at stop
    wr(8'h40);
    @(negedge clk); tb_sda_low = 1'b1; idle(8);
    @(negedge clk); tb_sda_low = 1'b0; idle(8);
    @(negedge clk); sh_scl = 1'b1; idle(2);
    chk("R7 scl released", scl_oe, 0);
    wr(8'h00); idle(2);
    chk("R7 scl restored", scl_oe, 1);
    @(negedge clk); sh_scl = 1'b0; idle(8);

    // R8 wait hold, internal then external clock
    for (int e = 0; e < 2; e++) begin
      ext_clk = e[0];
      wr(8'h80);
      @(negedge clk); tb_sda_low = 1'b1; idle(8);
      for (int i = 1; i <= 10; i++) begin
        @(negedge clk); tb_scl_low = 1'b1; idle(6);
        @(negedge clk); tb_scl_low = 1'b0; idle(6);
        if (i == 9) chk("R8 no hold before 10th", scl_oe, 0);
      end
      chk("R8 hold after 10th fall", scl_oe, e == 0 ? 1 : 0);
      wr(8'h00); idle(2);
      chk("R8 released", scl_oe, 0);
      idle(6);
      @(negedge clk); tb_sda_low = 1'b0; idle(8);
    end
    ext_clk = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule